// File: doc/BRIEF.md
# Serial Converter Frame Controller

This block is the device-side digital front end of a serial sampling converter. It watches a chip select, a frame sync, a serial clock, serial data in and an active-low conversion-start strobe. All of these arrive asynchronously and are resynchronised into the system clock domain. From them the block works out when an operation cycle begins. It counts serial clock rising edges within that cycle, captures a 4-bit command nibble, and controls the enable of the serial output driver.

Framing has two modes, and the level of frame sync at the moment chip select falls chooses between them. If frame sync is high, the cycle opens on that chip-select falling edge, as in a plain slave-select port. If frame sync is low, the cycle waits for the next rising edge of frame sync.

A separate path handles the strobe and runs independently of the serial framing. A falling strobe opens a sampling window, and the rising strobe puts the sample into hold and starts a stubbed conversion of fixed length. Strobes are refused until the eleventh counted serial clock edge has been seen. A strobe that falls during a conversion is flagged as an error.

Top module: `sconv_frame_ctrl`

## Requirements
- R1: After reset, the output enable, active flag, sample window, busy, error flag and clock counter are all zero.
- R2: While chip select is high, serial clock edges leave the counter and command unchanged, serial data is not captured, and the output enable stays low. A rising chip select ends the cycle.
- R3: A chip-select falling edge drives the output enable high and clears the clock counter to 0.
- R4: If frame sync is high when chip select falls, the cycle becomes active on that same edge.
- R5: If frame sync is low when chip select falls, the cycle stays inactive and no clock edges are counted until frame sync rises while chip select is still low.
- R6: In an active cycle, the counter adds one on each serial clock rising edge and holds at 15 once it gets there.
- R7: The serial data bits on the first four rising clock edges of a cycle form the command, with the first bit in bit 3 and the fourth bit in bit 0.
- R8: A strobe falling edge that comes before the 11th counted serial clock rising edge since reset is ignored. After that edge, strobes are accepted from then on.
- R9: An accepted strobe falling edge raises the sample output. The next strobe rising edge lowers it and holds busy high for exactly CONV_CYCLES system clocks.
- R10: A strobe falling edge while busy is high sets the error flag and does not open a sample window. The next accepted falling edge clears the flag.
- R11: The strobe path works whatever the levels of chip select and frame sync are, including while chip select is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Chip select, active low, asynchronous |
| fs_i | input | 1 | Frame sync, asynchronous |
| sclk_i | input | 1 | Serial clock, sampled in the system domain |
| sdi_i | input | 1 | Serial data in |
| cstart_n_i | input | 1 | Conversion-start strobe, active low, asynchronous |
| sdo_oe_o | output | 1 | Serial output driver enable (0 = high impedance) |
| cycle_active_o | output | 1 | Operation cycle in progress |
| clk_cnt_o | output | 4 | Serial clock rising edges counted in the cycle |
| cmd_o | output | 4 | Captured command nibble |
| sample_o | output | 1 | Sampling window open |
| busy_o | output | 1 | Hold and conversion in progress |
| strobe_err_o | output | 1 | Strobe fell during a conversion |

## Verification
The strobe path and the serial framing path are independent, so their events can land in the same system clock cycle. The bench forces this in two ways. It drives a chip-select falling edge, with frame sync high, in the same time step as a strobe falling edge. It also drives a serial clock rising edge in the same time step as a strobe rising edge. After each pair, the bench requires both effects to be present: the cycle has opened and a sample window is open, and then the counter has advanced by one and busy has started. A second kind of overlap is a strobe falling edge arriving while busy is high. The bench judges that case by the error flag and by the sample window staying closed.

// File: rtl/sconv_pkg.sv
package sconv_pkg;

  // Saturating increment of the serial clock edge counter
  function automatic logic [3:0] edge_cnt_next(input logic [3:0] c);
    return (c == 4'hF) ? c : c + 4'd1;
  endfunction

  // Shift one serial bit into the command, first bit ends in the MSB
  function automatic logic [3:0] cmd_shift(input logic [3:0] c, input logic b);
    return {c[2:0], b};
  endfunction

endpackage

// File: rtl/sconv_sync.sv
module sconv_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else if (s == 0) stg[s] <= d_i;
        else stg[s] <= stg[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/sconv_framer.sv
module sconv_framer
  import sconv_pkg::*;
#(
  parameter int GATE_EDGE = 11,
  parameter int CMD_BITS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_s,
  input  logic       fs_s,
  input  logic       sclk_s,
  input  logic       sdi_s,
  output logic       oe_o,
  output logic       active_o,
  output logic [3:0] cnt_o,
  output logic [3:0] cmd_o,
  output logic       gate_o
);

  localparam logic [3:0] GATE_M1 = 4'(GATE_EDGE - 1);
  localparam logic [3:0] CMD_N   = 4'(CMD_BITS);

  logic cs_d, fs_d, sclk_d, armed;
  logic cs_fall, cs_rise, fs_rise, sclk_rise;

  assign cs_fall   = cs_d & ~cs_s;
  assign cs_rise   = ~cs_d & cs_s;
  assign fs_rise   = ~fs_d & fs_s;
  assign sclk_rise = ~sclk_d & sclk_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d     <= 1'b1;
      fs_d     <= 1'b0;
      sclk_d   <= 1'b0;
      oe_o     <= 1'b0;
      active_o <= 1'b0;
      armed    <= 1'b0;
      cnt_o    <= '0;
      cmd_o    <= '0;
      gate_o   <= 1'b0;
    end else begin
      cs_d   <= cs_s;
      fs_d   <= fs_s;
      sclk_d <= sclk_s;
      if (cs_rise) begin
        oe_o     <= 1'b0;
        active_o <= 1'b0;
        armed    <= 1'b0;
      end else if (cs_fall) begin
        oe_o     <= 1'b1;
        cnt_o    <= '0;
        active_o <= fs_s;
        armed    <= ~fs_s;
      end else if (armed && fs_rise && !cs_s) begin
        active_o <= 1'b1;
        armed    <= 1'b0;
        cnt_o    <= '0;
      end else if (active_o && sclk_rise) begin
        cnt_o <= edge_cnt_next(cnt_o);
        if (cnt_o < CMD_N) cmd_o <= cmd_shift(cmd_o, sdi_s);
        if (cnt_o == GATE_M1) gate_o <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sconv_strobe.sv
module sconv_strobe #(
  parameter int CONV_CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic st_s,
  input  logic gate_i,
  output logic sample_o,
  output logic busy_o,
  output logic err_o
);

  localparam int CW = $clog2(CONV_CYCLES + 1);

  logic          st_d;
  logic          st_fall, st_rise;
  logic [CW-1:0] conv_cnt;

  assign st_fall = st_d & ~st_s;
  assign st_rise = ~st_d & st_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_d     <= 1'b1;
      sample_o <= 1'b0;
      busy_o   <= 1'b0;
      err_o    <= 1'b0;
      conv_cnt <= '0;
    end else begin
      st_d <= st_s;
      if (busy_o) begin
        conv_cnt <= conv_cnt - 1'b1;
        if (conv_cnt == CW'(1)) busy_o <= 1'b0;
      end
      if (st_fall) begin
        if (busy_o) err_o <= 1'b1;
        else if (gate_i) begin
          sample_o <= 1'b1;
          err_o    <= 1'b0;
        end
      end
      if (st_rise && sample_o) begin
        sample_o <= 1'b0;
        busy_o   <= 1'b1;
        conv_cnt <= CW'(CONV_CYCLES);
      end
    end
  end

endmodule

// File: rtl/sconv_frame_ctrl.sv
module sconv_frame_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int GATE_EDGE = 11,
  parameter int CMD_BITS = 4,
  parameter int CONV_CYCLES = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n_i,
  input  logic       fs_i,
  input  logic       sclk_i,
  input  logic       sdi_i,
  input  logic       cstart_n_i,
  output logic       sdo_oe_o,
  output logic       cycle_active_o,
  output logic [3:0] clk_cnt_o,
  output logic [3:0] cmd_o,
  output logic       sample_o,
  output logic       busy_o,
  output logic       strobe_err_o
);

  // Synchronised inputs, bit order: strobe, sdi, sclk, fs, cs
  localparam logic [4:0] SYNC_RST = 5'b10001;

  logic [4:0] raw_in, sync_out;
  logic       cs_sync, fs_sync, sclk_sync, sdi_sync, st_sync;
  logic       gate_open;

  assign raw_in = {cstart_n_i, sdi_i, sclk_i, fs_i, cs_n_i};
  assign {st_sync, sdi_sync, sclk_sync, fs_sync, cs_sync} = sync_out;

  sconv_sync #(.W(5), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw_in), .q_o(sync_out)
  );

  sconv_framer #(.GATE_EDGE(GATE_EDGE), .CMD_BITS(CMD_BITS)) u_framer (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_sync), .fs_s(fs_sync),
    .sclk_s(sclk_sync), .sdi_s(sdi_sync), .oe_o(sdo_oe_o),
    .active_o(cycle_active_o), .cnt_o(clk_cnt_o), .cmd_o(cmd_o),
    .gate_o(gate_open)
  );

  sconv_strobe #(.CONV_CYCLES(CONV_CYCLES)) u_strobe (
    .clk(clk), .rst_n(rst_n), .st_s(st_sync), .gate_i(gate_open),
    .sample_o(sample_o), .busy_o(busy_o), .err_o(strobe_err_o)
  );

endmodule

// File: rtl/sconv_frame_ctrl_chk.sv
module sconv_frame_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_sync,
  input logic       gate_open,
  input logic       sdo_oe_o,
  input logic       cycle_active_o,
  input logic [3:0] clk_cnt_o,
  input logic       sample_o,
  input logic       busy_o,
  input logic       strobe_err_o
);

  // R2
  cs_high_oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_sync |=> !sdo_oe_o);

  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (clk_cnt_o == $past(clk_cnt_o) || clk_cnt_o == 4'd0 ||
              clk_cnt_o == $past(clk_cnt_o) + 4'd1));

  // R4
  active_needs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cycle_active_o) |-> sdo_oe_o);

  // R8
  sample_after_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |-> gate_open);

  // R9
  sample_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_o && busy_o));

  // R10
  err_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_err_o) |-> $past(busy_o));

endmodule

bind sconv_frame_ctrl sconv_frame_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_sync(cs_sync), .gate_open(gate_open),
  .sdo_oe_o(sdo_oe_o), .cycle_active_o(cycle_active_o),
  .clk_cnt_o(clk_cnt_o), .sample_o(sample_o), .busy_o(busy_o),
  .strobe_err_o(strobe_err_o)
);

// File: tb/tb_sconv_frame_ctrl.sv
module tb_sconv_frame_ctrl;

  localparam int CONV = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, fs = 1'b0, sclk = 1'b0, sdi = 1'b0, st_n = 1'b1;
  logic oe, active, sample, busy, err;
  logic [3:0] cnt, cmd;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sconv_frame_ctrl #(.CONV_CYCLES(CONV)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .fs_i(fs), .sclk_i(sclk),
    .sdi_i(sdi), .cstart_n_i(st_n), .sdo_oe_o(oe), .cycle_active_o(active),
    .clk_cnt_o(cnt), .cmd_o(cmd), .sample_o(sample), .busy_o(busy),
    .strobe_err_o(err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sclk_pulse(input logic b);
    sdi = b;
    repeat (4) @(posedge clk);
    sclk = 1'b1;
    repeat (4) @(posedge clk);
    sclk = 1'b0;
    repeat (4) @(posedge clk);
  endtask

  task automatic measure_busy(output int len);
    len = 0;
    for (int i = 0; i < 20 && !busy; i++) @(negedge clk);
    while (busy && len < 1000) begin
      len++;
      @(negedge clk);
    end
  endtask

  int blen;
  logic [3:0] nib;

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    settle();
    // R1 reset state
    chk("R1 oe", oe, 0); chk("R1 active", active, 0); chk("R1 cnt", cnt, 0);
    chk("R1 sample", sample, 0); chk("R1 busy", busy, 0); chk("R1 err", err, 0);

    // R2 cs high: clocks and data ignored
    for (int i = 0; i < 3; i++) sclk_pulse(1'b1);
    settle();
    chk("R2 cnt", cnt, 0); chk("R2 cmd", cmd, 0); chk("R2 oe", oe, 0);

    // R8 strobe before gate ignored
    st_n = 1'b0; settle();
    chk("R8 sample", sample, 0);
    st_n = 1'b1; settle();
    chk("R8 busy", busy, 0);

    // R4 slave-select framing
    fs = 1'b1; settle();
    cs_n = 1'b0; settle();
    chk("R3 oe", oe, 1); chk("R4 active", active, 1); chk("R3 cnt", cnt, 0);
    nib = 4'b1011;
    for (int k = 1; k <= 17; k++) begin
      sclk_pulse(k <= 4 ? nib[4-k] : 1'b0);
      @(negedge clk);
      chk("R6 count", cnt, (k > 15) ? 15 : k);
    end
    chk("R7 cmd", cmd, 4'b1011);
    cs_n = 1'b1; settle();
    chk("R2 oe off", oe, 0); chk("R2 active off", active, 0);
    sclk_pulse(1'b0); settle();
    chk("R2 cnt hold", cnt, 15);

    // R5 frame-sync framing
    fs = 1'b0; settle();
    cs_n = 1'b0; settle();
    chk("R3 oe", oe, 1); chk("R3 cnt clr", cnt, 0); chk("R5 wait", active, 0);
    sclk_pulse(1'b1); sclk_pulse(1'b1); settle();
    chk("R5 no count", cnt, 0);
    fs = 1'b1; settle();
    chk("R5 active", active, 1);
    nib = 4'b0110;
    for (int k = 1; k <= 4; k++) sclk_pulse(nib[4-k]);
    settle();
    chk("R7 cmd", cmd, 4'b0110); chk("R6 cnt", cnt, 4);
    fs = 1'b0; cs_n = 1'b1; settle();

    // R9/R11 strobe with cs high, several window lengths
    for (int w = 1; w <= 4; w++) begin
      st_n = 1'b0; repeat (w * 3) @(posedge clk); settle();
      chk("R11 sample cs high", sample, 1);
      st_n = 1'b1;
      measure_busy(blen);
      chk("R9 busy length", blen, CONV);
      chk("R9 sample closed", sample, 0);
    end

    // R10 strobe fall while busy
    st_n = 1'b0; settle();
    st_n = 1'b1;
    for (int i = 0; i < 20 && !busy; i++) @(negedge clk);
    st_n = 1'b0; settle();
    chk("R10 err", err, 1); chk("R10 sample", sample, 0);
    repeat (CONV) @(posedge clk);
    st_n = 1'b1; settle();
    chk("R10 rise ignored", busy, 0);
    st_n = 1'b0; settle();
    chk("R10 sample again", sample, 1); chk("R10 err clear", err, 0);
    st_n = 1'b1; measure_busy(blen);
    chk("R9 busy length", blen, CONV);

    // Same-cycle events: cs fall with strobe fall, sclk rise with strobe rise
    fs = 1'b1; settle();
    cs_n = 1'b0; st_n = 1'b0; settle();
    chk("R4 active coincident", active, 1); chk("R11 sample coincident", sample, 1);
    sclk = 1'b1; st_n = 1'b1; repeat (4) @(posedge clk); @(negedge clk);
    chk("R6 cnt coincident", cnt, 1); chk("R9 busy coincident", busy, 1);
    sclk = 1'b0; measure_busy(blen);
    cs_n = 1'b1; settle();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule